// File: doc/BRIEF.md
# UART Interrupt Status and Routing Unit

This block gathers the interrupt events of a serial port into one eleven-bit raw status word, qualifies that word with a software-written enable word, and fans the result out to six interrupt lines. One line is the OR of every enabled event. Three lines each carry one event: receive, transmit and receive timeout. The last two lines each cover a group: the four modem-line change events, and the four receive error events (overrun, break, parity, framing).

Event sources raise set requests. A request may be a single-cycle pulse or a held level, because a set bit stays set until software clears it. A write to the transmit data register also sets the transmit bit. Software clears bits by writing ones to the clear port. It reads the raw word, the masked word and the enable word on three read-only buses. All six lines come from flops, so they follow any change in status or enable one clock later.

Top module: `uart_irq_router`

## Requirements
- R1: After reset the raw status, the enable word, the masked status and all six interrupt lines are zero.
- R2: Raw status bit positions are fixed: overrun 10, break 9, parity 8, framing 7, receive timeout 6, transmit 5, receive 4, DSR 3, DCD 2, CTS 1, ring 0. A set request on bit n sets raw bit n at the next clock edge, and the bit stays set until it is cleared.
- R3: A cycle with `tx_data_wr` high sets raw bit 5 at the next clock edge.
- R4: A cycle with `clr_we` high clears every raw bit whose `clr_data` bit is 1, at the next clock edge. Raw bits whose `clr_data` bit is 0 are left as they are.
- R5: If a set request (including `tx_data_wr` for bit 5) and a clear hit the same bit in one cycle, the bit ends up set.
- R6: A cycle with `en_we` high loads `en_data` into the enable word at the next edge. `masked_status` always equals the raw status ANDed with the enable word.
- R7: `irq_any` is the OR of all masked bits. `irq_rx` is masked bit 4, `irq_tx` is masked bit 5 and `irq_rtim` is masked bit 6.
- R8: `irq_modem` is the OR of masked bits 3:0. `irq_err` is the OR of masked bits 10:7.
- R9: Each interrupt line is registered. It reflects the raw status and enable word as they stood after the previous clock edge, so it changes one cycle after they do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | 11 | Per-bit set requests from the event sources |
| tx_data_wr | input | 1 | Write strobe of the transmit data register |
| clr_we | input | 1 | Strobe of the clear port |
| clr_data | input | 11 | Bits to clear |
| en_we | input | 1 | Strobe of the enable word write |
| en_data | input | 11 | New enable word |
| raw_status | output | 11 | Raw status read value |
| masked_status | output | 11 | Masked status read value |
| enable_mask | output | 11 | Enable word read value |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rtim | output | 1 | Receive timeout interrupt |
| irq_modem | output | 1 | Modem status group interrupt |
| irq_err | output | 1 | Error group interrupt |

## Verification
The raw status and the enable word change one edge after the stimulus, and the masked read value follows them in the same cycle. The interrupt lines trail by one more edge. The bench models all of this with integer shadow state, updated at each rising edge. It keeps the previous masked value to predict the lines. Every output is compared at the falling edge of every cycle, so each result is checked in the cycle it falls due, and a set and a clear that collide land in that same comparison.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int unsigned IRQ_W     = 11;
    localparam int unsigned LINE_CNT  = 6;

    localparam int unsigned BIT_RING  = 0;
    localparam int unsigned BIT_CTS   = 1;
    localparam int unsigned BIT_DCD   = 2;
    localparam int unsigned BIT_DSR   = 3;
    localparam int unsigned BIT_RX    = 4;
    localparam int unsigned BIT_TX    = 5;
    localparam int unsigned BIT_RTIM  = 6;
    localparam int unsigned BIT_FRAME = 7;
    localparam int unsigned BIT_PAR   = 8;
    localparam int unsigned BIT_BRK   = 9;
    localparam int unsigned BIT_OVR   = 10;

    typedef logic [IRQ_W-1:0] irq_vec_t;

    typedef enum logic [2:0] {
        LINE_ANY   = 3'd0,
        LINE_RX    = 3'd1,
        LINE_TX    = 3'd2,
        LINE_RTIM  = 3'd3,
        LINE_MODEM = 3'd4,
        LINE_ERR   = 3'd5
    } irq_line_e;

    typedef struct packed {
        logic     we;
        irq_vec_t data;
    } reg_wr_t;

    function automatic irq_vec_t line_group(input irq_line_e l);
        irq_vec_t g;
        g = '0;
        case (l)
            LINE_ANY:   g = '1;
            LINE_RX:    g[BIT_RX] = 1'b1;
            LINE_TX:    g[BIT_TX] = 1'b1;
            LINE_RTIM:  g[BIT_RTIM] = 1'b1;
            LINE_MODEM: g[BIT_DSR:BIT_RING] = '1;
            LINE_ERR:   g[BIT_OVR:BIT_FRAME] = '1;
            default:    g = '0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set_req,
    input  logic     tx_data_wr,
    input  reg_wr_t  clr_wr,
    output irq_vec_t status
);
    irq_vec_t set_all;
    irq_vec_t clr_vec;

    always_comb begin
        set_all = set_req;
        set_all[BIT_TX] = set_req[BIT_TX] | tx_data_wr;
        clr_vec = clr_wr.we ? clr_wr.data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_vec) | set_all;
    end

    // R5
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_all & clr_vec) != '0) |=> ((status & $past(set_all & clr_vec)) == $past(set_all & clr_vec)));
    // R4
    clear_effect_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr.we |=> ((status & $past(clr_wr.data & ~set_all)) == '0));
    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr.we |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  en_wr,
    output irq_vec_t enable
);
    always_ff @(posedge clk) begin
        if (rst)           enable <= '0;
        else if (en_wr.we) enable <= en_wr.data;
    end

    // R6
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_wr.we |=> $stable(enable));
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  irq_vec_t            masked,
    output logic [LINE_CNT-1:0] lines
);
    logic [LINE_CNT-1:0] next_lines;

    for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
        localparam irq_vec_t GRP = line_group(irq_line_e'(i));
        assign next_lines[i] = |(masked & GRP);
    end

    always_ff @(posedge clk) begin
        if (rst) lines <= '0;
        else     lines <= next_lines;
    end

    // R7
    any_covers_chk: assert property (@(posedge clk) disable iff (rst)
        (lines[LINE_ANY] == 1'b0) |-> (lines == '0));
    // R9
    lines_lag_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 (lines[LINE_ANY] == (|$past(masked))));
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
    import uart_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [10:0] set_req,
    input  logic        tx_data_wr,
    input  logic        clr_we,
    input  logic [10:0] clr_data,
    input  logic        en_we,
    input  logic [10:0] en_data,
    output logic [10:0] raw_status,
    output logic [10:0] masked_status,
    output logic [10:0] enable_mask,
    output logic        irq_any,
    output logic        irq_rx,
    output logic        irq_tx,
    output logic        irq_rtim,
    output logic        irq_modem,
    output logic        irq_err
);
    reg_wr_t             clr_wr;
    reg_wr_t             en_wr;
    irq_vec_t            st;
    irq_vec_t            en;
    irq_vec_t            msk;
    logic [LINE_CNT-1:0] lines;

    assign clr_wr = '{we: clr_we, data: clr_data};
    assign en_wr  = '{we: en_we, data: en_data};

    uart_irq_status u_status (
        .clk(clk), .rst(rst), .set_req(set_req), .tx_data_wr(tx_data_wr),
        .clr_wr(clr_wr), .status(st)
    );

    uart_irq_mask u_mask (
        .clk(clk), .rst(rst), .en_wr(en_wr), .enable(en)
    );

    assign msk = st & en;

    uart_irq_lines u_lines (
        .clk(clk), .rst(rst), .masked(msk), .lines(lines)
    );

    assign raw_status    = st;
    assign masked_status = msk;
    assign enable_mask   = en;
    assign irq_any   = lines[LINE_ANY];
    assign irq_rx    = lines[LINE_RX];
    assign irq_tx    = lines[LINE_TX];
    assign irq_rtim  = lines[LINE_RTIM];
    assign irq_modem = lines[LINE_MODEM];
    assign irq_err   = lines[LINE_ERR];

    // R3
    tx_write_sets_chk: assert property (@(posedge clk) disable iff (rst)
        tx_data_wr |=> raw_status[BIT_TX]);
    // R8
    err_group_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 (irq_err == (|$past(masked_status[BIT_OVR:BIT_FRAME]))));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (raw_status == '0 && enable_mask == '0 && !irq_any));
endmodule

// File: tb/uart_irq_router_test.sv
module uart_irq_router_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] set_req = '0;
    logic        tx_data_wr = 1'b0;
    logic        clr_we = 1'b0;
    logic [10:0] clr_data = '0;
    logic        en_we = 1'b0;
    logic [10:0] en_data = '0;
    logic [10:0] raw_status, masked_status, enable_mask;
    logic        irq_any, irq_rx, irq_tx, irq_rtim, irq_modem, irq_err;

    int checks = 0;
    int fails  = 0;
    int m_raw = 0, m_en = 0, m_lines = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    uart_irq_router uut (.*);

    function automatic int lines_of(input int m);
        int l;
        l = 0;
        if (m != 0)              l |= 1;
        if ((m >> 4) & 1)        l |= 2;
        if ((m >> 5) & 1)        l |= 4;
        if ((m >> 6) & 1)        l |= 8;
        if ((m & 'h00F) != 0)    l |= 16;
        if ((m & 'h780) != 0)    l |= 32;
        return l;
    endfunction

    always @(posedge clk) begin
        int s;
        if (rst) begin
            m_raw = 0; m_en = 0; m_lines = 0;
        end else begin
            m_lines = lines_of(m_raw & m_en);
            s = int'(set_req) | (tx_data_wr ? 'h20 : 0);
            m_raw = ((m_raw & ~(clr_we ? int'(clr_data) : 0)) | s) & 'h7FF;
            if (en_we) m_en = int'(en_data);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int act_lines();
        return {26'd0, irq_err, irq_modem, irq_rtim, irq_tx, irq_rx, irq_any};
    endfunction

    always @(negedge clk) begin
        if (model_on) begin
            chk("R2/R4/R5 raw", int'(raw_status), m_raw);
            chk("R6 enable", int'(enable_mask), m_en);
            chk("R6 masked", int'(masked_status), m_raw & m_en);
            chk("R7/R8/R9 lines", act_lines(), m_lines);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            set_req = '0; tx_data_wr = 0; clr_we = 0; en_we = 0;
        end
    endtask

    task automatic step(input logic [10:0] s, input logic tx, input logic cw,
                        input logic [10:0] cd, input logic ew, input logic [10:0] ed);
        set_req = s; tx_data_wr = tx; clr_we = cw; clr_data = cd; en_we = ew; en_data = ed;
        idle(1);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 raw", int'(raw_status), 0);
        chk("R1 en", int'(enable_mask), 0);
        chk("R1 lines", act_lines(), 0);
        model_on = 1;
        // R2 sets with mask zero, lines stay low
        step(11'h001, 0, 0, 0, 0, 0);
        idle(2);
        // R6/R7 enable all
        step(0, 0, 0, 0, 1, 11'h7FF);
        idle(2);
        // R3 tx write
        step(0, 1, 0, 0, 0, 0);
        idle(2);
        // R2 each bit individually, then clear R4
        for (int b = 0; b < 11; b++) begin
            step(11'(1 << b), 0, 0, 0, 0, 0);
            idle(1);
            step(0, 0, 1, 11'h7FF, 0, 0);
            idle(1);
        end
        // R8 group masks
        step(0, 0, 0, 0, 1, 11'h00F);
        step(11'h780, 0, 0, 0, 0, 0);
        idle(2);
        step(11'h004, 0, 0, 0, 0, 0);
        idle(2);
        step(0, 0, 0, 0, 1, 11'h780);
        idle(2);
        // R4 partial clear
        step(0, 0, 1, 11'h100, 0, 0);
        idle(2);
        step(0, 0, 1, 11'h000, 0, 0);
        idle(1);
        // R5 collision
        step(11'h010, 0, 1, 11'h7FF, 1, 11'h7FF);
        idle(2);
        step(0, 1, 1, 11'h020, 0, 0);
        idle(2);
        // level requests held
        set_req = 11'h040;
        idle(0);
        for (int i = 0; i < 4; i++) begin set_req = 11'h040; clr_we = 1; clr_data = 11'h040; @(posedge clk); #1; end
        idle(3);
        // pseudo-random sweep
        for (int i = 0; i < 300; i++) begin
            int r;
            r = (i * 1103 + 7) ^ (i << 5);
            step(11'(r & (((i % 3) == 0) ? 'h7FF : 'h111)), r[12], r[13], 11'(r >> 3),
                 ((i % 7) == 0), 11'(r >> 1));
        end
        idle(3);
        model_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule